// File: doc/BRIEF.md
# Mode-Selectable Inverting Bus Transceiver

This block is the datapath of a 9-bit bidirectional transceiver. It sits between a three-state A port and an open-collector B port. The B port is a wired-AND bus, so its drivers can only pull a line low or let it go. Each direction passes its data through one storage element. A shared two-bit select sets that element to one of three behaviours:

- combinational pass-through;
- a transparent latch;
- an edge-triggered register.

One select setting is asymmetric. Every direction has its own strobe input. Whatever the mode, the output is the bitwise inverse of the input.

The block is built for a synchronous fabric. The strobes are sampled by the system clock `clk`:

- In register mode, a rising strobe is detected as a low-to-high change between two clock edges.
- In latch mode, the output follows the input combinationally while the strobe is low. The element captures the input at every clock edge at which the strobe is low.

The B port appears as two vectors:

- a per-line pull-low control, which this device drives;
- a resolved bus level, which combines that control with the pulls of the other agents and with the presence of the bus termination.

Top module: `inv_bus_xcvr`

## Requirements
- R1: The select `sel` carries two bits, SEL1 in `sel[1]` and SEL0 in `sel[0]`. The setting applies to the storage element of each direction as follows:
  - `00`: latch in both directions.
  - `01`: pass-through in both directions.
  - `10`: register in both directions.
  - `11`: register from A to B, latch from B to A.
- R2: In pass-through, the outputs are the combinational inverse of the inputs in the same cycle. `b_pull` equals `a_in` while the B port is enabled, and `a_out` equals `~b_level`.
- R3: In register mode, a direction captures its input at a clock edge at which its strobe is 1 and was 0 at the previous edge. The output changes only after that edge. Holding the strobe high captures nothing more.
- R4: In latch mode, the output follows the inverse of the input combinationally while the strobe is low. While the strobe is high, the output holds the input captured at the last clock edge at which the strobe was low.
- R5: With `sel=11`, the A-to-B path holds its data until a strobe rise. Over the same interval, the B-to-A path is transparent while `le_ba` is low.
- R6: `a_oe` is 1 exactly when `oe_a` is 1. `a_out` carries the B-to-A data whatever the value of `a_oe`.
- R7: Line i of `b_pull` is asserted (1 = pulling low) only when `oeb_hi`=1, `oeb_lo_n`=0 and the inverted A-to-B data bit i is 0. In every other case all nine lines are 0 (released).
- R8: `b_level[i] = bus_term & ~b_pull[i] & ~b_ext_pull[i]`. With `bus_term`=0, a line that nothing drives reads 0.
- R9: The storage elements keep capturing data while their outputs are disabled. Re-enabling an output then shows the data captured meanwhile.
- R10: A synchronous reset (active low) loads all ones into both storage elements and clears the strobe history to high. In register mode after reset, `b_pull` is 1FF and `a_out` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and storage |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 2 | Mode select, {SEL1, SEL0} |
| le_ab | input | 1 | A-to-B strobe: clock in register mode, low-true enable in latch mode |
| le_ba | input | 1 | B-to-A strobe, same meaning |
| oe_a | input | 1 | A port drive enable, active high |
| oeb_hi | input | 1 | B port enable qualifier, active high |
| oeb_lo_n | input | 1 | B port enable qualifier, active low |
| bus_term | input | 1 | 1 when the bus pull-up termination is present |
| a_in | input | 9 | Data received on the A port |
| b_ext_pull | input | 9 | Pull-low from other bus agents, 1 = pulling |
| a_out | output | 9 | A port data (inverted B-to-A data) |
| a_oe | output | 1 | A port driver enable |
| b_pull | output | 9 | This device's B line pull-low, 1 = pulling |
| b_level | output | 9 | Resolved B bus level |

## Verification
The bench first checks the outputs while a strobe is already high but before the clock edge that samples the rise. A register that captured on a level would change there too early, and a register that ignored the history would capture again while the strobe stays high. It changes the input while a latch is held. A design that stayed transparent would show the new value, and one that held the value present at the rise rather than at the last low edge would differ in the transparent-then-hold sequence. It also checks the following cases, each of which a design that got it wrong would show as the wrong level on a bus line:
- both disabling combinations of the two B qualifiers, which a design that swapped a polarity would still drive;
- a missing termination, which must read low;
- external pulls, which must dominate the resolved level;
- the asymmetric setting, which must not be decoded as symmetric.

// File: rtl/inv_xcvr_pkg.sv
// Shared types for the inverting bus transceiver.
// Assumes nothing beyond the mode select encoding given in the brief.
package inv_xcvr_pkg;

    // Behaviour of one direction's storage element.
    typedef enum logic [1:0] {
        STG_PASS  = 2'd0,
        STG_LATCH = 2'd1,
        STG_REG   = 2'd2
    } stage_mode_e;

endpackage

// File: rtl/inv_xcvr_mode_dec.sv
// Decodes the shared two-bit select into one storage behaviour per direction.
// Assumes sel[1] is SEL1 and sel[0] is SEL0; the decode is purely combinational.
module inv_xcvr_mode_dec
    import inv_xcvr_pkg::*;
(
    input  logic [1:0]  sel,
    output stage_mode_e mode_ab,
    output stage_mode_e mode_ba
);

    // Map each select setting onto a behaviour for each direction.
    always_comb begin
        unique case (sel)
            2'b00: begin mode_ab = STG_LATCH; mode_ba = STG_LATCH; end
            2'b01: begin mode_ab = STG_PASS;  mode_ba = STG_PASS;  end
            2'b10: begin mode_ab = STG_REG;   mode_ba = STG_REG;   end
            default: begin mode_ab = STG_REG; mode_ba = STG_LATCH; end
        endcase
    end

endmodule

// File: rtl/inv_xcvr_stage.sv
// One direction's storage element with an inverting output.
// In register mode it captures when the strobe was low at the previous clock edge
// and is high at this one. In latch mode it captures at every edge with the strobe low,
// and its output is transparent while the strobe is low.
// Assumes the strobe is synchronous to clk.
module inv_xcvr_stage
    import inv_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stage_mode_e      mode,
    input  logic             le,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic             le_q;
    logic             cap;
    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] chosen;

    // Remember the strobe level from the previous edge for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b1;
        else        le_q <= le;
    end

    // Decide whether the element loads the input at this edge.
    always_comb begin
        unique case (mode)
            STG_REG:   cap = le & ~le_q;
            STG_LATCH: cap = ~le;
            default:   cap = 1'b0;
        endcase
    end

    // Storage element, loaded with all ones by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   store_q <= '1;
        else if (cap) store_q <= din;
    end

    // Select the transparent input or the stored word.
    always_comb begin
        unique case (mode)
            STG_LATCH: chosen = le ? store_q : din;
            STG_REG:   chosen = store_q;
            default:   chosen = din;
        endcase
    end

    assign dout = ~chosen;

endmodule

// File: rtl/inv_xcvr_bport.sv
// Open-collector B port model: per-line pull-low control and wired-AND resolution.
// Assumes drv_data is already inverted. A line pulls low where it is 0 and the port is enabled.
module inv_xcvr_bport #(
    parameter int WIDTH = 9
) (
    input  logic             en_hi,
    input  logic             en_lo_n,
    input  logic             term,
    input  logic [WIDTH-1:0] drv_data,
    input  logic [WIDTH-1:0] ext_pull,
    output logic [WIDTH-1:0] pull,
    output logic [WIDTH-1:0] level
);

    logic en;

    // Qualify the drivers with one active-high and one active-low enable.
    assign en = en_hi & ~en_lo_n;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        // Pull a line low for a zero data bit; resolve it against the other agents.
        assign pull[i]  = en & ~drv_data[i];
        assign level[i] = term & ~pull[i] & ~ext_pull[i];
    end

endmodule

// File: rtl/inv_bus_xcvr.sv
// Top of the inverting bus transceiver.
// Decodes the mode, then builds two storage stages and the B port.
// The A-to-B stage feeds the B pull-low control. The B-to-A stage takes the resolved
// B bus, so this device's own pull is visible on its A side.
// Assumes the strobes and enables are synchronous to clk.
module inv_bus_xcvr #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             le_ab,
    input  logic             le_ba,
    input  logic             oe_a,
    input  logic             oeb_hi,
    input  logic             oeb_lo_n,
    input  logic             bus_term,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_ext_pull,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_pull,
    output logic [WIDTH-1:0] b_level
);

    import inv_xcvr_pkg::*;

    stage_mode_e      mode_ab;
    stage_mode_e      mode_ba;
    logic [WIDTH-1:0] ab_inv;
    logic [WIDTH-1:0] ba_inv;

    inv_xcvr_mode_dec u_dec (
        .sel     (sel),
        .mode_ab (mode_ab),
        .mode_ba (mode_ba)
    );

    inv_xcvr_stage #(.WIDTH(WIDTH)) u_stage_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_ab),
        .le    (le_ab),
        .din   (a_in),
        .dout  (ab_inv)
    );

    inv_xcvr_bport #(.WIDTH(WIDTH)) u_bport (
        .en_hi    (oeb_hi),
        .en_lo_n  (oeb_lo_n),
        .term     (bus_term),
        .drv_data (ab_inv),
        .ext_pull (b_ext_pull),
        .pull     (b_pull),
        .level    (b_level)
    );

    inv_xcvr_stage #(.WIDTH(WIDTH)) u_stage_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_ba),
        .le    (le_ba),
        .din   (b_level),
        .dout  (ba_inv)
    );

    // A port data and its drive enable.
    assign a_out = ba_inv;
    assign a_oe  = oe_a;

endmodule

// File: rtl/inv_bus_xcvr_chk.sv
// Temporal checks for the inverting bus transceiver, bound to the top module.
// Assumes reset is asserted from time zero.
module inv_bus_xcvr_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel,
    input logic             le_ab,
    input logic             oeb_hi,
    input logic             oeb_lo_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_pull,
    input logic [WIDTH-1:0] b_ext_pull,
    input logic [WIDTH-1:0] b_level
);

    // Register mode: a strobe rise loads a_in, visible on the B pulls one cycle later.
    p_reg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && le_ab && !$past(le_ab))
        |=> ((sel == 2'b10 && oeb_hi && !oeb_lo_n) |-> (b_pull == $past(a_in))));

    // Latch mode: with the strobe held high and the port enabled, the pulls do not move.
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && $past(sel) == 2'b00 && le_ab && $past(le_ab)
         && oeb_hi && !oeb_lo_n && $past(oeb_hi) && !$past(oeb_lo_n))
        |-> $stable(b_pull));

    // Pass-through: the A side shows the inverse of the resolved bus.
    p_pass_invert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01) |-> (a_out == ~b_level));

    // Any disabling combination of the qualifiers releases every B line.
    p_b_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(oeb_hi && !oeb_lo_n) |-> (b_pull == '0));

    // A line pulled low by anyone never resolves high.
    p_wired_and_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_level & (b_pull | b_ext_pull)) == '0));

endmodule

bind inv_bus_xcvr inv_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .le_ab      (le_ab),
    .oeb_hi     (oeb_hi),
    .oeb_lo_n   (oeb_lo_n),
    .a_in       (a_in),
    .a_out      (a_out),
    .b_pull     (b_pull),
    .b_ext_pull (b_ext_pull),
    .b_level    (b_level)
);

// File: tb/inv_bus_xcvr_bench.sv
// Scoreboard bench: the driver pushes expected port values, the monitor compares them.
module inv_bus_xcvr_bench;

    localparam int W = 9;

    typedef struct {
        string        req;
        logic [W-1:0] ea;
        logic         eoe;
        logic [W-1:0] ep;
        logic [W-1:0] el;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   sel = 2'b10;
    logic         le_ab = 1'b0, le_ba = 1'b0, oe_a = 1'b1;
    logic         oeb_hi = 1'b1, oeb_lo_n = 1'b0, bus_term = 1'b1;
    logic [W-1:0] a_in = '0, b_ext_pull = '0;
    logic [W-1:0] a_out, b_pull, b_level;
    logic         a_oe;

    item_t q[$];
    int    total = 0, bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    inv_bus_xcvr #(.WIDTH(W)) u_inv_bus_xcvr (
        .clk(clk), .rst_n(rst_n), .sel(sel), .le_ab(le_ab), .le_ba(le_ba),
        .oe_a(oe_a), .oeb_hi(oeb_hi), .oeb_lo_n(oeb_lo_n), .bus_term(bus_term),
        .a_in(a_in), .b_ext_pull(b_ext_pull), .a_out(a_out), .a_oe(a_oe),
        .b_pull(b_pull), .b_level(b_level)
    );

    // Resolved level from R8.
    function automatic logic [W-1:0] lvl(input logic [W-1:0] p, input logic [W-1:0] x,
                                         input logic t);
        return t ? ~(p | x) : '0;
    endfunction

    task automatic expect_now(input string r, input logic [W-1:0] ea, input logic eoe,
                              input logic [W-1:0] ep, input logic [W-1:0] el);
        item_t it;
        it.req = r; it.ea = ea; it.eoe = eoe; it.ep = ep; it.el = el;
        q.push_back(it);
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    // Monitor: compares every pending item shortly after the falling edge.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (a_out !== it.ea || a_oe !== it.eoe || b_pull !== it.ep || b_level !== it.el) begin
                bad++;
                $display("FAIL %s: a_out=%h a_oe=%b b_pull=%h b_level=%h expected %h %b %h %h",
                         it.req, a_out, a_oe, b_pull, b_level, it.ea, it.eoe, it.ep, it.el);
            end
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        expect_now("R10 reset state", 9'h000, 1'b1, 9'h1FF, 9'h000);

        // R1 / R2 pass-through
        step(); sel = 2'b01; a_in = 9'h0A5;
        expect_now("R2 pass pattern 1", 9'h0A5, 1'b1, 9'h0A5, 9'h15A);
        step(); a_in = 9'h1C3; b_ext_pull = 9'h024;
        expect_now("R8 external pull", 9'h1E7, 1'b1, 9'h1C3, lvl(9'h1C3, 9'h024, 1'b1));
        step(); oe_a = 1'b0;
        expect_now("R6 A disabled", 9'h1E7, 1'b0, 9'h1C3, 9'h018);
        step(); oe_a = 1'b1; oeb_hi = 1'b0;
        expect_now("R7 oeb_hi low", 9'h024, 1'b1, 9'h000, 9'h1DB);
        step(); oeb_hi = 1'b1; oeb_lo_n = 1'b1;
        expect_now("R7 oeb_lo_n high", 9'h024, 1'b1, 9'h000, 9'h1DB);
        step(); oeb_lo_n = 1'b0; bus_term = 1'b0;
        expect_now("R8 no termination", 9'h1FF, 1'b1, 9'h1C3, 9'h000);

        // R3 register mode, A to B
        step(); bus_term = 1'b1; b_ext_pull = '0; sel = 2'b10; a_in = 9'h0F0;
        expect_now("R3 hold before rise", 9'h000, 1'b1, 9'h1FF, 9'h000);
        step(); le_ab = 1'b1;
        expect_now("R3 no change before edge", 9'h000, 1'b1, 9'h1FF, 9'h000);
        step(); a_in = 9'h00F;
        expect_now("R3 captured on rise", 9'h000, 1'b1, 9'h0F0, 9'h10F);
        step();
        expect_now("R3 level high no recapture", 9'h000, 1'b1, 9'h0F0, 9'h10F);

        // R3 register mode, B to A
        step(); oeb_hi = 1'b0; b_ext_pull = 9'h0AA;
        expect_now("R3 BA before rise", 9'h000, 1'b1, 9'h000, 9'h155);
        step(); le_ba = 1'b1;
        expect_now("R3 BA no change before edge", 9'h000, 1'b1, 9'h000, 9'h155);
        step();
        expect_now("R3 BA captured", 9'h0AA, 1'b1, 9'h000, 9'h155);

        // R4 latch mode
        step(); sel = 2'b00; oeb_hi = 1'b1; b_ext_pull = '0; le_ab = 1'b0; a_in = 9'h123;
        expect_now("R4 transparent 1", 9'h0AA, 1'b1, 9'h123, 9'h0DC);
        step(); a_in = 9'h0C4;
        expect_now("R4 transparent 2", 9'h0AA, 1'b1, 9'h0C4, 9'h13B);
        step(); le_ab = 1'b1; a_in = 9'h1FF;
        expect_now("R4 hold after close", 9'h0AA, 1'b1, 9'h0C4, 9'h13B);
        step();
        expect_now("R4 still held", 9'h0AA, 1'b1, 9'h0C4, 9'h13B);

        // R9 capture while disabled
        step(); sel = 2'b10; oeb_hi = 1'b0; a_in = 9'h055; le_ab = 1'b0;
        expect_now("R9 disabled", 9'h0AA, 1'b1, 9'h000, 9'h1FF);
        step(); le_ab = 1'b1;
        expect_now("R9 disabled at rise", 9'h0AA, 1'b1, 9'h000, 9'h1FF);
        step();
        expect_now("R9 disabled after capture", 9'h0AA, 1'b1, 9'h000, 9'h1FF);
        step(); oeb_hi = 1'b1;
        expect_now("R9 re-enabled shows capture", 9'h0AA, 1'b1, 9'h055, 9'h1AA);

        // R5 asymmetric setting
        step(); sel = 2'b11; le_ab = 1'b0; a_in = 9'h1AA;
        expect_now("R5 AB register holds", 9'h0AA, 1'b1, 9'h055, 9'h1AA);
        step(); le_ab = 1'b1;
        expect_now("R5 AB no change before edge", 9'h0AA, 1'b1, 9'h055, 9'h1AA);
        step();
        expect_now("R5 AB captured, BA held", 9'h0AA, 1'b1, 9'h1AA, 9'h055);
        step(); le_ba = 1'b0;
        expect_now("R5 BA latch transparent", 9'h1AA, 1'b1, 9'h1AA, 9'h055);

        step(); step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule